// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This block is the shift/rotate datapath of an integer execution pipeline. It takes one 32-bit operand per cycle with a 3-bit operation code and a count, and computes one of seven operations: plain rotate left or right, rotate left or right through the carry flag, logical shift left or right, and arithmetic shift right. It registers the result, the new flag values and a separate write enable for each flag. The register file and flag register downstream use those enables to apply only the flags the operation defines. All other flags keep their old values.

The count comes from one of three sources, chosen by a 2-bit select: an immediate, the constant one, or a count register. The immediate and register values are reduced to their low five bits. An effective count of zero turns the operation into a no-op. The result write enable and all flag enables stay low, and the result port carries the operand unchanged. Rotate through carry treats the incoming carry and the 32 operand bits as one 33-bit ring. Overflow is only defined for a count of one. For larger counts its enable stays low, so the flag register keeps its prior value.

Top module: `shift_rot_unit`

## Requirements
- R1: The effective count is `imm_cnt[4:0]` when `cnt_src` is 0, the constant 1 when `cnt_src` is 1, and `cnt_reg[4:0]` when `cnt_src` is 2 or 3.
- R2: With `op_valid` high and an effective count of zero, the next cycle shows `res_we` and all five flag enables low, and `result` equals the operand.
- R3: Plain rotates. Code 0 rotates left and code 1 rotates right by n. The carry is result bit 0 after a left rotate and result bit 31 after a right rotate.
- R4: Rotate through carry. Code 2 is left and code 3 is right, over the 33-bit ring {carry, operand}. On a left rotate the incoming carry lands at bit n-1 and the new carry is operand bit 32-n. On a right rotate the incoming carry lands at bit 32-n and the new carry is operand bit n-1.
- R5: Operation codes 0 to 3 raise only `cf_we`, and `of_we` when n is 1. `sf_we`, `zf_we` and `pf_we` stay low.
- R6: Logical shifts. Code 4 shifts left and code 5 shifts right, with zero fill. The carry is the last bit shifted out: operand bit 32-n for a left shift and operand bit n-1 for a right shift.
- R7: Code 7 is an arithmetic right shift. It fills the vacated bits with operand bit 31, and its carry is operand bit n-1.
- R8: For shift codes 4 to 7 with a non-zero count, the sign, zero and parity flags are written. Sign is result bit 31. Zero is 1 when the result is 0. Parity is 1 when the low 8 result bits hold an even number of ones.
- R9: `of_we` is high only when n is 1. Overflow is then result bit 31 XOR operand bit 31, except for code 7, which writes 0.
- R10: Code 6 behaves exactly like code 4.
- R11: Outputs are registered with one cycle of latency. After reset every output is 0.
- R12: When `op_valid` is low, the next cycle shows `res_we` and all flag enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 3 | Operation code (R3, R4, R6, R7, R10) |
| cnt_src | input | 2 | Count source select (R1) |
| imm_cnt | input | 8 | Immediate count |
| cnt_reg | input | 8 | Count register value |
| operand | input | 32 | Value to shift or rotate |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Registered result |
| res_we | output | 1 | Result write enable |
| cf_out | output | 1 | New carry flag |
| of_out | output | 1 | New overflow flag |
| sf_out | output | 1 | New sign flag |
| zf_out | output | 1 | New zero flag |
| pf_out | output | 1 | New parity flag |
| cf_we | output | 1 | Carry write enable |
| of_we | output | 1 | Overflow write enable |
| sf_we | output | 1 | Sign write enable |
| zf_we | output | 1 | Zero write enable |
| pf_we | output | 1 | Parity write enable |

## Verification
The bench targets register counts whose upper bits are set but whose low five bits are zero. A design that masked the count wrongly would then perform a shift where a no-op is required, or the reverse. It drives rotate-through-carry at counts 1 and 31 with both carry values, where an off-by-one in the 33-bit ring would misplace the incoming carry or return the wrong outgoing bit. It also drives arithmetic right shifts of negative operands at count 1, where a design that reused the logical-shift overflow rule would report overflow. It checks that rotates never raise the sign, zero or parity enables.

// File: rtl/shift_rot_pkg.sv
`timescale 1ns/1ps
package shift_rot_pkg;
  typedef enum logic [2:0] {
    OP_ROL  = 3'd0,
    OP_ROR  = 3'd1,
    OP_RCL  = 3'd2,
    OP_RCR  = 3'd3,
    OP_SHL  = 3'd4,
    OP_SHR  = 3'd5,
    OP_SHLA = 3'd6,
    OP_SAR  = 3'd7
  } sr_op_e;

  typedef enum logic [1:0] {
    CS_IMM  = 2'd0,
    CS_ONE  = 2'd1,
    CS_REG  = 2'd2,
    CS_REG2 = 2'd3
  } cnt_src_e;

  typedef struct packed {
    logic cf;
    logic of;
    logic sf;
    logic zf;
    logic pf;
  } flag_vec_t;
endpackage

// File: rtl/sr_count_sel.sv
`timescale 1ns/1ps
module sr_count_sel #(
  parameter int CIN_W = 8,
  parameter int CNT_W = 5
) (
  input  logic [1:0]       src,
  input  logic [CIN_W-1:0] imm_val,
  input  logic [CIN_W-1:0] reg_val,
  output logic [CNT_W-1:0] eff_cnt,
  output logic             cnt_zero,
  output logic             cnt_one
);
  import shift_rot_pkg::*;

  // Upper count bits are discarded by definition (R1).
  logic unused_hi;
  assign unused_hi = ^{imm_val[CIN_W-1:CNT_W], reg_val[CIN_W-1:CNT_W]};

  always_comb begin
    case (src)
      CS_IMM:  eff_cnt = imm_val[CNT_W-1:0];
      CS_ONE:  eff_cnt = CNT_W'(1);
      default: eff_cnt = reg_val[CNT_W-1:0];
    endcase
  end

  assign cnt_zero = (eff_cnt == '0);
  assign cnt_one  = (eff_cnt == CNT_W'(1));
endmodule

// File: rtl/sr_rotator.sv
`timescale 1ns/1ps
module sr_rotator #(
  parameter int W     = 32,
  parameter int CNT_W = 5
) (
  input  logic [W-1:0]     val,
  input  logic             cin,
  input  logic [CNT_W-1:0] cnt,
  input  logic             go_right,
  input  logic             thru_carry,
  output logic [W-1:0]     res,
  output logic             cout
);
  localparam int RW = W + 1;

  function automatic logic [W-1:0] rot_left(input logic [W-1:0] v, input logic [CNT_W-1:0] n);
    logic [2*W-1:0] d;
    d = {v, v} << n;
    return d[2*W-1:W];
  endfunction

  function automatic logic [W-1:0] rot_right(input logic [W-1:0] v, input logic [CNT_W-1:0] n);
    logic [2*W-1:0] d;
    d = {v, v} >> n;
    return d[W-1:0];
  endfunction

  function automatic logic [RW-1:0] ring_left(input logic [RW-1:0] r, input logic [CNT_W-1:0] n);
    logic [2*RW-1:0] d;
    d = {r, r} << n;
    return d[2*RW-1:RW];
  endfunction

  function automatic logic [RW-1:0] ring_right(input logic [RW-1:0] r, input logic [CNT_W-1:0] n);
    logic [2*RW-1:0] d;
    d = {r, r} >> n;
    return d[RW-1:0];
  endfunction

  logic [RW-1:0] ring_in, ring_out;
  logic [W-1:0]  plain_res;

  assign ring_in   = {cin, val};
  assign ring_out  = go_right ? ring_right(ring_in, cnt) : ring_left(ring_in, cnt);
  assign plain_res = go_right ? rot_right(val, cnt) : rot_left(val, cnt);

  always_comb begin
    if (thru_carry) begin
      res  = ring_out[W-1:0];
      cout = ring_out[W];
    end else begin
      res  = plain_res;
      cout = go_right ? plain_res[W-1] : plain_res[0];
    end
  end
endmodule

// File: rtl/sr_shifter.sv
`timescale 1ns/1ps
module sr_shifter #(
  parameter int W     = 32,
  parameter int CNT_W = 5
) (
  input  logic [W-1:0]     val,
  input  logic [CNT_W-1:0] cnt,
  input  logic             go_right,
  input  logic             arith,
  output logic [W-1:0]     res,
  output logic             cout
);
  // Left: the extra top bit catches the last bit shifted out.
  function automatic logic [W:0] shift_up(input logic [W-1:0] v, input logic [CNT_W-1:0] n);
    return {1'b0, v} << n;
  endfunction

  // Right: the extra low bit catches the last bit shifted out.
  function automatic logic [W:0] shift_down(input logic [W-1:0] v, input logic [CNT_W-1:0] n,
                                            input logic sgn);
    logic signed [W:0] s;
    s = $signed({v, 1'b0});
    if (sgn) return s >>> n;
    return {v, 1'b0} >> n;
  endfunction

  logic [W:0] up_w, dn_w;
  assign up_w = shift_up(val, cnt);
  assign dn_w = shift_down(val, cnt, arith);

  always_comb begin
    if (go_right) begin
      res  = dn_w[W:1];
      cout = dn_w[0];
    end else begin
      res  = up_w[W-1:0];
      cout = up_w[W];
    end
  end
endmodule

// File: rtl/sr_flags.sv
`timescale 1ns/1ps
module sr_flags #(
  parameter int W     = 32,
  parameter int PAR_W = 8
) (
  input  logic [W-1:0] res,
  input  logic         opd_msb,
  input  logic         cout,
  input  logic         go,
  input  logic         is_rot,
  input  logic         is_sar,
  input  logic         cnt_one,
  output shift_rot_pkg::flag_vec_t flg,
  output shift_rot_pkg::flag_vec_t flg_we
);
  function automatic logic even_parity(input logic [PAR_W-1:0] b);
    return ~(^b);
  endfunction

  logic sign_flip;
  assign sign_flip = res[W-1] ^ opd_msb;

  always_comb begin
    flg.cf = cout;
    flg.of = is_sar ? 1'b0 : sign_flip;
    flg.sf = res[W-1];
    flg.zf = (res == '0);
    flg.pf = even_parity(res[PAR_W-1:0]);

    flg_we.cf = go;
    flg_we.of = go & cnt_one;
    flg_we.sf = go & ~is_rot;
    flg_we.zf = go & ~is_rot;
    flg_we.pf = go & ~is_rot;
  end
endmodule

// File: rtl/shift_rot_unit.sv
`timescale 1ns/1ps
module shift_rot_unit #(
  parameter int W     = 32,
  parameter int CIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [2:0]       op_sel,
  input  logic [1:0]       cnt_src,
  input  logic [CIN_W-1:0] imm_cnt,
  input  logic [CIN_W-1:0] cnt_reg,
  input  logic [W-1:0]     operand,
  input  logic             carry_in,
  output logic [W-1:0]     result,
  output logic             res_we,
  output logic             cf_out,
  output logic             of_out,
  output logic             sf_out,
  output logic             zf_out,
  output logic             pf_out,
  output logic             cf_we,
  output logic             of_we,
  output logic             sf_we,
  output logic             zf_we,
  output logic             pf_we
);
  import shift_rot_pkg::*;

  localparam int CNT_W = $clog2(W);

  // Named internal events
  logic [CNT_W-1:0] eff_cnt;
  logic             cnt_zero, cnt_one;
  logic             is_rot, thru_carry, go_right, is_sar, go;
  logic [W-1:0]     rot_res, sh_res, nxt_res;
  logic             rot_c, sh_c, nxt_c;
  flag_vec_t        nxt_flg, nxt_we;

  sr_count_sel #(.CIN_W(CIN_W), .CNT_W(CNT_W)) u_cnt (
    .src(cnt_src), .imm_val(imm_cnt), .reg_val(cnt_reg),
    .eff_cnt(eff_cnt), .cnt_zero(cnt_zero), .cnt_one(cnt_one)
  );

  // Codes 0-3 rotate, 4-7 shift; bit 0 picks right; bit 1 picks through-carry.
  assign is_rot     = ~op_sel[2];
  assign thru_carry = op_sel[1];
  assign go_right   = op_sel[0];
  assign is_sar     = (op_sel == OP_SAR);
  assign go         = op_valid & ~cnt_zero;

  sr_rotator #(.W(W), .CNT_W(CNT_W)) u_rot (
    .val(operand), .cin(carry_in), .cnt(eff_cnt), .go_right(go_right),
    .thru_carry(thru_carry), .res(rot_res), .cout(rot_c)
  );

  sr_shifter #(.W(W), .CNT_W(CNT_W)) u_sh (
    .val(operand), .cnt(eff_cnt), .go_right(go_right), .arith(is_sar),
    .res(sh_res), .cout(sh_c)
  );

  assign nxt_res = cnt_zero ? operand : (is_rot ? rot_res : sh_res);
  assign nxt_c   = is_rot ? rot_c : sh_c;

  sr_flags #(.W(W)) u_flg (
    .res(nxt_res), .opd_msb(operand[W-1]), .cout(nxt_c), .go(go),
    .is_rot(is_rot), .is_sar(is_sar), .cnt_one(cnt_one),
    .flg(nxt_flg), .flg_we(nxt_we)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      res_we <= 1'b0;
      {cf_out, of_out, sf_out, zf_out, pf_out} <= '0;
      {cf_we, of_we, sf_we, zf_we, pf_we}      <= '0;
    end else begin
      result <= nxt_res;
      res_we <= go;
      {cf_out, of_out, sf_out, zf_out, pf_out} <= nxt_flg;
      {cf_we, of_we, sf_we, zf_we, pf_we}      <= nxt_we;
    end
  end

  assert_zero_cnt_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cnt_zero) |=> (!res_we && !cf_we && !of_we && !sf_we && !zf_we && !pf_we));

  assert_rol_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !cnt_zero && op_sel == OP_ROL) |=> (cf_out == result[0]));

  assert_rot_keeps_szp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_rot) |=> (!sf_we && !zf_we && !pf_we));

  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    zf_we |-> (zf_out == (result == '0)));

  assert_sar_no_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_sar && cnt_one) |=> (of_we && !of_out));

  assert_ovf_only_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !cnt_one) |=> !of_we);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!res_we && !cf_we && !of_we));
endmodule

// File: tb/shift_rot_unit_bench.sv
`timescale 1ns/1ps
module shift_rot_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [1:0]  cnt_src = '0;
  logic [7:0]  imm_cnt = '0, cnt_reg = '0;
  logic [31:0] operand = '0;
  logic        carry_in = 1'b0;
  logic [31:0] result;
  logic        res_we, cf_out, of_out, sf_out, zf_out, pf_out;
  logic        cf_we, of_we, sf_we, zf_we, pf_we;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  shift_rot_unit u_shift_rot_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel), .cnt_src(cnt_src),
    .imm_cnt(imm_cnt), .cnt_reg(cnt_reg), .operand(operand), .carry_in(carry_in),
    .result(result), .res_we(res_we), .cf_out(cf_out), .of_out(of_out), .sf_out(sf_out),
    .zf_out(zf_out), .pf_out(pf_out), .cf_we(cf_we), .of_we(of_we), .sf_we(sf_we),
    .zf_we(zf_we), .pf_we(pf_we)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One operation: drive at a falling edge, compare at the next falling edge.
  task automatic step(input bit v, input logic [2:0] op, input logic [1:0] src,
                      input logic [7:0] imm, input logic [7:0] creg,
                      input logic [31:0] opd, input bit cin, input string force_tag);
    int n;
    logic [31:0] x;
    logic c, t, e_of;
    int ones;
    string tg;
    bit rot, sh;
    op_valid = v; op_sel = op; cnt_src = src; imm_cnt = imm; cnt_reg = creg;
    operand = opd; carry_in = cin;
    // R1: count source
    if (src == 2'd0) n = int'(imm) % 32;
    else if (src == 2'd1) n = 1;
    else n = int'(creg) % 32;
    x = opd; c = cin;
    for (int k = 0; k < n; k++) begin
      case (op)
        3'd0: begin x = {x[30:0], x[31]}; end
        3'd1: begin x = {x[0], x[31:1]}; end
        3'd2: begin t = x[31]; x = {x[30:0], c}; c = t; end
        3'd3: begin t = x[0]; x = {c, x[31:1]}; c = t; end
        3'd5: begin c = x[0]; x = x >> 1; end
        3'd7: begin c = x[0]; x = {x[31], x[31:1]}; end
        default: begin c = x[31]; x = x << 1; end
      endcase
    end
    if (op == 3'd0) c = x[0];
    if (op == 3'd1) c = x[31];
    ones = 0;
    for (int b = 0; b < 8; b++) ones += int'(x[b]);
    e_of = (op == 3'd7) ? 1'b0 : (x[31] ^ opd[31]);
    rot = (op < 3'd4);
    sh  = !rot;
    if (force_tag != "") tg = force_tag;
    else if (op < 3'd2) tg = "R3";
    else if (op < 3'd4) tg = "R4";
    else if (op == 3'd6) tg = "R10";
    else if (op == 3'd7) tg = "R7";
    else tg = "R6";
    @(negedge clk);
    if (!v) begin
      chk("R12", "res_we idle", res_we, 0);
      chk("R12", "enables idle", {cf_we, of_we, sf_we, zf_we, pf_we}, 0);
    end else if (n == 0) begin
      chk((force_tag != "") ? force_tag : "R2", "res_we zero count", res_we, 0);
      chk("R2", "enables zero count", {cf_we, of_we, sf_we, zf_we, pf_we}, 0);
      chk("R2", "result zero count", result, opd);
    end else begin
      chk(tg, "res_we", res_we, 1);
      chk(tg, "result", result, x);
      chk(tg, "cf_we", cf_we, 1);
      chk(tg, "carry", cf_out, c);
      chk("R9", "of_we", of_we, (n == 1));
      if (n == 1) chk("R9", "overflow", of_out, e_of);
      chk(rot ? "R5" : "R8", "szp enables", {sf_we, zf_we, pf_we}, sh ? 3'b111 : 3'b000);
      if (sh) begin
        chk("R8", "sign", sf_out, x[31]);
        chk("R8", "zero", zf_out, (x == 0));
        chk("R8", "parity", pf_out, (ones % 2 == 0));
      end
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "result after reset", result, 0);
    chk("R11", "res_we after reset", res_we, 0);
    chk("R11", "enables after reset", {cf_we, of_we, sf_we, zf_we, pf_we}, 0);
    chk("R11", "flags after reset", {cf_out, of_out, sf_out, zf_out, pf_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: count sources and masking
    step(1, 3'd4, 2'd0, 8'h21, 8'h00, 32'h8000_0001, 0, "R1");
    step(1, 3'd5, 2'd2, 8'h00, 8'hE0, 32'h1234_5678, 0, "R1");
    step(1, 3'd5, 2'd3, 8'h00, 8'h44, 32'hF000_000F, 0, "R1");
    step(1, 3'd1, 2'd1, 8'h00, 8'h00, 32'h0000_0001, 0, "R1");
    step(1, 3'd0, 2'd0, 8'h20, 8'h00, 32'hDEAD_BEEF, 1, "");
    // R4: ring corners
    step(1, 3'd2, 2'd1, 8'h00, 8'h00, 32'h8000_0000, 1, "R4");
    step(1, 3'd2, 2'd0, 8'd31, 8'h00, 32'h0000_0003, 1, "R4");
    step(1, 3'd3, 2'd1, 8'h00, 8'h00, 32'h0000_0001, 0, "R4");
    step(1, 3'd3, 2'd2, 8'h00, 8'd31, 32'hC000_0000, 1, "R4");
    // R7 / R9: arithmetic shift of negative values
    step(1, 3'd7, 2'd1, 8'h00, 8'h00, 32'h8000_0000, 0, "R7");
    step(1, 3'd7, 2'd0, 8'd31, 8'h00, 32'h8000_0001, 0, "R7");
    // R10: alias code
    step(1, 3'd6, 2'd1, 8'h00, 8'h00, 32'h4000_0000, 0, "R10");
    step(1, 3'd6, 2'd0, 8'd4, 8'h00, 32'h0F00_00F0, 0, "R10");
    // R6: shift out everything but one bit
    step(1, 3'd4, 2'd0, 8'd31, 8'h00, 32'h0000_0001, 0, "R6");
    step(1, 3'd5, 2'd0, 8'd31, 8'h00, 32'h8000_0000, 0, "R6");
    // R12: idle
    step(0, 3'd4, 2'd1, 8'h00, 8'h00, 32'hFFFF_FFFF, 1, "R12");
    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] val;
      case ($urandom_range(0, 5))
        0: val = 32'h0;
        1: val = 32'hFFFF_FFFF;
        2: val = 32'h8000_0000;
        default: val = $urandom;
      endcase
      step($urandom_range(0, 9) != 0, 3'($urandom), 2'($urandom), 8'($urandom),
           8'($urandom), val, 1'($urandom), "");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule